// File: doc/BRIEF.md
# Zero-Suppressing Event Readout Formatter

This block holds the conversion results of one eight-channel event and turns them into a stream of 16-bit words on a ready/valid output. When an event is captured, each channel's 12-bit value is compared against that channel's own lower and upper window. A channel whose value falls inside its window is counted as valid. The event, the validity pattern and the configuration in force at capture time are all latched. They stay fixed until an explicit clear.

Three readout modes exist. The compressed stream sends a header with the station number and the count of valid channels, then a presence bitmap, then only the valid channels' data words in ascending channel order. The full stream sends all eight data words in channel order and ignores the windows. In addressed mode, a request with an address returns one channel's data word, the header or the bitmap. A host uses the block by capturing an event and draining the stream until `done_o` rises, or by issuing addressed reads. It then clears the block for the next event.

Top module: `zs_readout`

## Requirements
- R1: After reset, and in the cycle after `clr_i` is high, `busy_o`, `done_o` and `word_valid_o` are all 0. `clr_i` aborts a stream in progress.
- R2: A `capture_i` pulse while `busy_o` is 1 has no effect. The values already held are the ones read out.
- R3: Channel i is valid when lo <= v[11:4] <= hi. Here lo = floor(L*26/256) and hi = 255 - floor(U*39/256), with L and U the channel's 8-bit lower and upper thresholds.
- R4: Compressed mode (`seq_mode_i`=1, `compress_i`=1) emits three kinds of word, in this order. First a header {station[7:0], 4'b0, valid count[3:0]}. Then a bitmap {8'b0, p[7:0]}, where bit i is set when channel i is valid. Then the data word of each valid channel in ascending channel order.
- R5: Full mode (`seq_mode_i`=1, `compress_i`=0) emits exactly eight data words for channels 0 to 7, regardless of validity.
- R6: A data word has three fields. Bits [11:0] hold the value. Bit 12 holds the overflow flag, or 0 when `ovf_hide_i` was 1 at capture. Bits [15:13] hold the channel number, or 0 when `chan_hide_i` was 1 at capture.
- R7: In compressed mode, an event with no valid channel emits no word, and `done_o` is 1 in the cycle after capture.
- R8: In addressed mode (`seq_mode_i`=0, `compress_i` ignored), `rd_req_i` with `rd_addr_i` set selects one word. Addresses 0-7 return that channel's data word, 14 returns the header and 15 returns the bitmap. Addresses 8-13 produce no word.
- R9: While `word_valid_o` is 1 and `word_ready_i` is 0, `word_o` and `word_valid_o` hold.
- R10: `busy_o` rises in the cycle after a capture and falls only on clear. `done_o` rises after the last stream word is accepted, and no word is offered after it.
- R11: Station number, mode and hide bits are taken at capture. Changing them afterwards does not alter the held event's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Discard the held event and return to idle |
| capture_i | input | 1 | Latch the event inputs when idle |
| value_i | input | 96 | Eight 12-bit conversion values, channel 0 in the low bits |
| ovf_i | input | 8 | Per-channel overflow flags |
| lo_thr_i | input | 64 | Eight 8-bit lower thresholds |
| hi_thr_i | input | 64 | Eight 8-bit upper thresholds |
| station_i | input | 8 | Virtual station number |
| seq_mode_i | input | 1 | 1: sequential stream, 0: addressed reads |
| compress_i | input | 1 | In sequential mode, 1 selects the compressed stream |
| ovf_hide_i | input | 1 | 1 forces the overflow bit of data words to 0 |
| chan_hide_i | input | 1 | 1 forces the channel field of data words to 0 |
| rd_req_i | input | 1 | Addressed read request |
| rd_addr_i | input | 4 | Addressed read selector |
| word_o | output | 16 | Output word |
| word_valid_o | output | 1 | Output word is valid |
| word_ready_i | input | 1 | Sink accepts the word |
| busy_o | output | 1 | An event is held |
| done_o | output | 1 | Stream finished |

## Verification
A corrupted bitmap or stale search index shows at the ports within one accepted word. The next data word carries a wrong channel field, or the word count differs from what the header promised. A wrong state after a clear, or after an ignored capture, shows one cycle later as an unexpected `busy_o`, or as a word whose value belongs to a different event. Latching the configuration at the wrong moment surfaces on the first header or data word after the live inputs are changed.

// File: rtl/zs_pkg.sv
package zs_pkg;
    parameter int NCH      = 8;
    parameter int VW       = 12;
    parameter int TW       = 8;
    parameter int SW       = 8;
    parameter int WW       = 16;
    parameter int AW       = 4;
    parameter int LO_NUM   = 26;
    parameter int HI_NUM   = 39;
    parameter int HDR_ADDR = 14;
    parameter int PAT_ADDR = 15;
    localparam int CHW     = $clog2(NCH);
    localparam int CW      = $clog2(NCH + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_PAT, ST_DATA, ST_DONE, ST_AWAIT, ST_AOUT
    } seq_state_e;

    typedef enum logic [1:0] {RM_COMPRESS, RM_FULL, RM_ADDR} rd_mode_e;

    typedef struct packed {
        logic            chan_en;
        logic            ovf_en;
        rd_mode_e        mode;
        logic [SW-1:0]   station;
    } cfg_t;

    typedef struct packed {
        logic           found;
        logic [CHW-1:0] idx;
    } srch_t;

    function automatic rd_mode_e decode_mode(input logic seq, input logic comp);
        if (!seq)      return RM_ADDR;
        else if (comp) return RM_COMPRESS;
        else           return RM_FULL;
    endfunction

    function automatic logic [TW-1:0] lo_code(input logic [TW-1:0] t);
        logic [2*TW-1:0] p;
        p = {{TW{1'b0}}, t} * (2*TW)'(LO_NUM);
        return p[2*TW-1:TW];
    endfunction

    function automatic logic [TW-1:0] hi_code(input logic [TW-1:0] t);
        logic [2*TW-1:0] p;
        p = {{TW{1'b0}}, t} * (2*TW)'(HI_NUM);
        return {TW{1'b1}} - p[2*TW-1:TW];
    endfunction

    function automatic logic in_window(input logic [VW-1:0] v,
                                       input logic [TW-1:0] lo,
                                       input logic [TW-1:0] hi);
        logic [TW-1:0] coarse;
        coarse = v[VW-1 -: TW];
        return (coarse >= lo_code(lo)) && (coarse <= hi_code(hi));
    endfunction

    function automatic logic [WW-1:0] data_word(input logic [CHW-1:0] ch,
                                                input logic ovf,
                                                input logic [VW-1:0] val,
                                                input cfg_t cfg);
        logic [WW-1:0] w;
        w = '0;
        w[VW-1:0]     = val;
        w[VW]         = ovf & cfg.ovf_en;
        w[WW-1 -: CHW] = cfg.chan_en ? ch : '0;
        return w;
    endfunction

    function automatic srch_t find_from(input logic [NCH-1:0] pat, input int start);
        srch_t r;
        r = '0;
        for (int i = 0; i < NCH; i++) begin
            if (!r.found && i >= start && pat[i]) begin
                r.found = 1'b1;
                r.idx   = CHW'(i);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/zs_window.sv
module zs_window
    import zs_pkg::*;
(
    input  logic [NCH*VW-1:0] value_i,
    input  logic [NCH*TW-1:0] lo_thr_i,
    input  logic [NCH*TW-1:0] hi_thr_i,
    output logic [NCH-1:0]    pat_o,
    output logic [CW-1:0]     cnt_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign pat_o[g] = in_window(value_i[g*VW +: VW],
                                    lo_thr_i[g*TW +: TW],
                                    hi_thr_i[g*TW +: TW]);
    end

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < NCH; i++) cnt_o = cnt_o + CW'(pat_o[i]);
    end
endmodule

// File: rtl/zs_sequencer.sv
module zs_sequencer
    import zs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_i,
    input  logic            start_i,
    input  rd_mode_e        mode_live_i,
    input  logic [NCH-1:0]  pat_live_i,
    input  rd_mode_e        mode_q_i,
    input  logic [NCH-1:0]  pat_q_i,
    input  logic            rd_req_i,
    input  logic [AW-1:0]   rd_addr_i,
    input  logic            ready_i,
    output seq_state_e      state_o,
    output logic [CHW-1:0]  idx_o,
    output logic [AW-1:0]   sel_o,
    output logic            valid_o,
    output logic            busy_o,
    output logic            done_o
);
    seq_state_e     state;
    logic [CHW-1:0] idx;
    logic [AW-1:0]  sel;
    srch_t          first_hit, next_hit;
    logic           addr_ok;

    assign first_hit = find_from(pat_q_i, 0);
    assign next_hit  = find_from(pat_q_i, int'(idx) + 1);
    assign addr_ok   = (int'(rd_addr_i) < NCH) || (int'(rd_addr_i) == HDR_ADDR)
                       || (int'(rd_addr_i) == PAT_ADDR);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            state <= ST_IDLE;
            idx   <= '0;
            sel   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    idx <= '0;
                    case (mode_live_i)
                        RM_COMPRESS: state <= (pat_live_i == '0) ? ST_DONE : ST_HDR;
                        RM_FULL:     state <= ST_DATA;
                        default:     state <= ST_AWAIT;
                    endcase
                end
                ST_HDR: if (ready_i) state <= ST_PAT;
                ST_PAT: if (ready_i) begin
                    state <= ST_DATA;
                    idx   <= first_hit.idx;
                end
                ST_DATA: if (ready_i) begin
                    if (mode_q_i == RM_FULL) begin
                        if (int'(idx) == NCH - 1) state <= ST_DONE;
                        else                      idx   <= idx + 1'b1;
                    end else if (next_hit.found) begin
                        idx <= next_hit.idx;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_AWAIT: if (rd_req_i && addr_ok) begin
                    state <= ST_AOUT;
                    sel   <= rd_addr_i;
                end
                ST_AOUT: if (ready_i) state <= ST_AWAIT;
                default: state <= state;
            endcase
        end
    end

    assign state_o = state;
    assign idx_o   = idx;
    assign sel_o   = sel;
    assign valid_o = (state == ST_HDR) || (state == ST_PAT) ||
                     (state == ST_DATA) || (state == ST_AOUT);
    assign busy_o  = (state != ST_IDLE);
    assign done_o  = (state == ST_DONE);
endmodule

// File: rtl/zs_formatter.sv
module zs_formatter
    import zs_pkg::*;
(
    input  seq_state_e        state_i,
    input  logic [CHW-1:0]    idx_i,
    input  logic [AW-1:0]     sel_i,
    input  logic [NCH*VW-1:0] val_q_i,
    input  logic [NCH-1:0]    ovf_q_i,
    input  logic [NCH-1:0]    pat_q_i,
    input  logic [CW-1:0]     cnt_q_i,
    input  cfg_t              cfg_q_i,
    output logic [WW-1:0]     word_o
);
    logic [CHW-1:0] ch;
    logic [WW-1:0]  hdr_w, pat_w, dat_w;
    logic           want_hdr, want_pat;

    assign ch       = (state_i == ST_AOUT) ? sel_i[CHW-1:0] : idx_i;
    assign hdr_w    = {cfg_q_i.station, {(WW-SW-CW){1'b0}}, cnt_q_i};
    assign pat_w    = {{(WW-NCH){1'b0}}, pat_q_i};
    assign dat_w    = data_word(ch, ovf_q_i[ch], val_q_i[int'(ch)*VW +: VW], cfg_q_i);
    assign want_hdr = (state_i == ST_HDR) ||
                      ((state_i == ST_AOUT) && (int'(sel_i) == HDR_ADDR));
    assign want_pat = (state_i == ST_PAT) ||
                      ((state_i == ST_AOUT) && (int'(sel_i) == PAT_ADDR));

    always_comb begin
        if (want_hdr)      word_o = hdr_w;
        else if (want_pat) word_o = pat_w;
        else               word_o = dat_w;
    end
endmodule

// File: rtl/zs_readout.sv
module zs_readout
    import zs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  capture_i,
    input  logic [NCH*VW-1:0]     value_i,
    input  logic [NCH-1:0]        ovf_i,
    input  logic [NCH*TW-1:0]     lo_thr_i,
    input  logic [NCH*TW-1:0]     hi_thr_i,
    input  logic [SW-1:0]         station_i,
    input  logic                  seq_mode_i,
    input  logic                  compress_i,
    input  logic                  ovf_hide_i,
    input  logic                  chan_hide_i,
    input  logic                  rd_req_i,
    input  logic [AW-1:0]         rd_addr_i,
    output logic [WW-1:0]         word_o,
    output logic                  word_valid_o,
    input  logic                  word_ready_i,
    output logic                  busy_o,
    output logic                  done_o
);
    logic [NCH-1:0]    pat_live, pat_q, ovf_q;
    logic [CW-1:0]     cnt_live, cnt_q;
    logic [NCH*VW-1:0] val_q;
    cfg_t              cfg_live, cfg_q;
    logic              start;
    seq_state_e        state;
    logic [CHW-1:0]    idx;
    logic [AW-1:0]     sel;

    assign cfg_live = '{chan_en: !chan_hide_i, ovf_en: !ovf_hide_i,
                        mode: decode_mode(seq_mode_i, compress_i), station: station_i};
    assign start    = capture_i && !busy_o && !clr_i;

    zs_window u_window (
        .value_i (value_i),
        .lo_thr_i(lo_thr_i),
        .hi_thr_i(hi_thr_i),
        .pat_o   (pat_live),
        .cnt_o   (cnt_live)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            ovf_q <= '0;
            pat_q <= '0;
            cnt_q <= '0;
            cfg_q <= '0;
        end else if (start) begin
            val_q <= value_i;
            ovf_q <= ovf_i;
            pat_q <= pat_live;
            cnt_q <= cnt_live;
            cfg_q <= cfg_live;
        end
    end

    zs_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr_i),
        .start_i    (start),
        .mode_live_i(cfg_live.mode),
        .pat_live_i (pat_live),
        .mode_q_i   (cfg_q.mode),
        .pat_q_i    (pat_q),
        .rd_req_i   (rd_req_i),
        .rd_addr_i  (rd_addr_i),
        .ready_i    (word_ready_i),
        .state_o    (state),
        .idx_o      (idx),
        .sel_o      (sel),
        .valid_o    (word_valid_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    zs_formatter u_fmt (
        .state_i(state),
        .idx_i  (idx),
        .sel_i  (sel),
        .val_q_i(val_q),
        .ovf_q_i(ovf_q),
        .pat_q_i(pat_q),
        .cnt_q_i(cnt_q),
        .cfg_q_i(cfg_q),
        .word_o (word_o)
    );
endmodule

// File: rtl/zs_readout_chk.sv
module zs_readout_chk
    import zs_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          clr_i,
    input logic          capture_i,
    input logic [WW-1:0] word_o,
    input logic          word_valid_o,
    input logic          word_ready_i,
    input logic          busy_o,
    input logic          done_o
);
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !busy_o && !word_valid_o && !done_o); // R1

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        word_valid_o && !word_ready_i && !clr_i |=> word_valid_o && $stable(word_o)); // R9

    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (rst)
        busy_o && !clr_i |=> busy_o); // R10

    AST_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (rst)
        capture_i && !clr_i |=> busy_o); // R10

    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o && !word_valid_o); // R7
endmodule

bind zs_readout zs_readout_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (clr_i),
    .capture_i   (capture_i),
    .word_o      (word_o),
    .word_valid_o(word_valid_o),
    .word_ready_i(word_ready_i),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/zs_readout_test.sv
module zs_readout_test;
    logic        clk = 0, rst = 1, clr_i = 0, capture_i = 0;
    logic [95:0] value_i = '0;
    logic [7:0]  ovf_i = '0;
    logic [63:0] lo_thr_i = '0, hi_thr_i = '0;
    logic [7:0]  station_i = '0;
    logic        seq_mode_i = 1, compress_i = 1, ovf_hide_i = 0, chan_hide_i = 0;
    logic        rd_req_i = 0;
    logic [3:0]  rd_addr_i = '0;
    logic [15:0] word_o;
    logic        word_valid_o, word_ready_i = 0, busy_o, done_o;

    int errors = 0, checks = 0;

    logic [11:0] bv[8];
    logic        bo[8];
    logic [7:0]  blo[8], bhi[8];
    logic [7:0]  e_st;
    logic        e_oh, e_ch;

    zs_readout uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit bvalid(int ch);
        int coarse, lo, hi;
        coarse = int'(bv[ch]) / 16;
        lo = (int'(blo[ch]) * 26) / 256;
        hi = 255 - (int'(bhi[ch]) * 39) / 256;
        return coarse >= lo && coarse <= hi;
    endfunction

    function automatic logic [7:0] bpat();
        logic [7:0] p = '0;
        for (int i = 0; i < 8; i++) p[i] = bvalid(i);
        return p;
    endfunction

    function automatic logic [15:0] bword(int ch);
        logic [15:0] w;
        w[11:0]  = bv[ch];
        w[12]    = bo[ch] && !e_oh;
        w[15:13] = e_ch ? 3'd0 : 3'(ch);
        return w;
    endfunction

    function automatic logic [15:0] bhdr();
        return {e_st, 4'd0, 4'($countones(bpat()))};
    endfunction

    task automatic rand_event();
        for (int i = 0; i < 8; i++) begin
            case ($urandom % 4)
                0:       bv[i] = 12'($urandom % 512);
                1:       bv[i] = 12'(3584 + $urandom % 512);
                default: bv[i] = 12'($urandom);
            endcase
            bo[i]  = 1'($urandom);
            blo[i] = 8'($urandom);
            bhi[i] = 8'($urandom);
        end
        e_st = 8'($urandom);
        e_oh = 1'($urandom);
        e_ch = 1'($urandom);
    endtask

    task automatic cap(input int mode);
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            value_i[i*12 +: 12] = bv[i];
            ovf_i[i]            = bo[i];
            lo_thr_i[i*8 +: 8]  = blo[i];
            hi_thr_i[i*8 +: 8]  = bhi[i];
        end
        station_i   = e_st;
        ovf_hide_i  = e_oh;
        chan_hide_i = e_ch;
        seq_mode_i  = (mode != 2);
        compress_i  = (mode == 0) ? 1'b1 : 1'($urandom);
        if (mode == 1) compress_i = 1'b0;
        capture_i   = 1;
        @(negedge clk);
        capture_i   = 0;
    endtask

    task automatic take(output logic [15:0] w, output bit got, input int hold, input string req);
        got = 0;
        w = '0;
        for (int k = 0; k < 20 && !got; k++) begin
            @(negedge clk);
            if (word_valid_o) begin
                w = word_o;
                got = 1;
                for (int h = 0; h < hold; h++) begin
                    @(negedge clk);
                    chk(word_valid_o && word_o == w, "R9", word_o, w);
                end
                word_ready_i = 1;
                @(negedge clk);
                word_ready_i = 0;
            end
        end
        if (!got) chk(0, req, 16'hxxxx, 16'h0);
    endtask

    task automatic clear();
        @(negedge clk);
        clr_i = 1;
        @(negedge clk);
        clr_i = 0;
        chk(!busy_o && !done_o && !word_valid_o, "R1", {13'd0, busy_o, done_o, word_valid_o}, 16'd0);
    endtask

    task automatic run_stream(input int mode, input int hold);
        logic [15:0] exp[10];
        logic [15:0] w;
        bit got;
        int n = 0;
        logic [7:0] p = bpat();
        cap(mode);
        if (mode == 0) begin
            if (p == 0) begin
                chk(done_o && !word_valid_o, "R7", {14'd0, done_o, word_valid_o}, 16'd2);
                clear();
                return;
            end
            exp[n++] = bhdr();
            exp[n++] = {8'd0, p};
            for (int i = 0; i < 8; i++) if (p[i]) exp[n++] = bword(i);
        end else begin
            for (int i = 0; i < 8; i++) exp[n++] = bword(i);
        end
        for (int j = 0; j < n; j++) begin
            take(w, got, (j == 1) ? hold : 0, (mode == 0) ? "R4" : "R5");
            chk(w == exp[j], (mode == 0) ? ((j < 2) ? "R4" : "R6 R3") : "R5 R6", w, exp[j]);
        end
        chk(done_o && !word_valid_o && busy_o, "R10", {13'd0, busy_o, done_o, word_valid_o}, 16'd6);
        clear();
    endtask

    task automatic rd(input int addr, output logic [15:0] w, output bit got);
        @(negedge clk);
        rd_req_i = 1;
        rd_addr_i = 4'(addr);
        @(negedge clk);
        rd_req_i = 0;
        take(w, got, 0, "R8");
    endtask

    initial begin
        logic [15:0] w;
        bit got;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy_o && !done_o && !word_valid_o, "R1", {13'd0, busy_o, done_o, word_valid_o}, 16'd0);

        // R3 boundaries: coarse 24/25 against lo code 25, 217/218 against hi code 217
        for (int i = 0; i < 8; i++) begin bv[i] = 12'd2048; bo[i] = 0; blo[i] = 0; bhi[i] = 0; end
        bv[0] = 12'd384; blo[0] = 8'd255;
        bv[1] = 12'd400; blo[1] = 8'd255;
        bv[2] = 12'd3487; bhi[2] = 8'd255;
        bv[3] = 12'd3488; bhi[3] = 8'd255;
        e_st = 8'hA5; e_oh = 0; e_ch = 0;
        cap(0);
        take(w, got, 0, "R4");
        chk(w == 16'hA506, "R4", w, 16'hA506);
        take(w, got, 0, "R3");
        chk(w == 16'h00F6, "R3", w, 16'h00F6);
        take(w, got, 0, "R6");
        chk(w == 16'h2190, "R6", w, 16'h2190);
        clear();

        // R7 all-invalid event
        for (int i = 0; i < 8; i++) begin bv[i] = 12'd0; blo[i] = 8'd255; end
        run_stream(0, 0);

        // R9 stall inside a full stream
        rand_event();
        run_stream(1, 3);

        // R1 clear mid-stream
        rand_event();
        for (int i = 0; i < 8; i++) begin blo[i] = 0; bhi[i] = 0; end
        cap(0);
        take(w, got, 0, "R4");
        clear();
        repeat (2) @(negedge clk);
        chk(!word_valid_o && !busy_o, "R1", {14'd0, busy_o, word_valid_o}, 16'd0);

        // R8 / R2 / R11 addressed reads
        rand_event();
        e_oh = 0; e_ch = 0; bo[3] = 1;
        cap(2);
        chk(!word_valid_o && busy_o && !done_o, "R8", {13'd0, busy_o, done_o, word_valid_o}, 16'd4);
        for (int i = 0; i < 8; i++) value_i[i*12 +: 12] = ~bv[i];
        station_i = ~e_st; ovf_hide_i = 1; chan_hide_i = 1;
        capture_i = 1;
        @(negedge clk);
        capture_i = 0;
        for (int a = 0; a < 8; a++) begin
            rd(a, w, got);
            chk(w == bword(a), "R2 R11 R8", w, bword(a));
        end
        rd(14, w, got);
        chk(w == bhdr(), "R8 R11", w, bhdr());
        rd(15, w, got);
        chk(w == {8'd0, bpat()}, "R8", w, {8'd0, bpat()});
        @(negedge clk);
        rd_req_i = 1; rd_addr_i = 4'd9;
        @(negedge clk);
        rd_req_i = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!word_valid_o, "R8", {15'd0, word_valid_o}, 16'd0);
        end
        clear();

        // random mix
        for (int e = 0; e < 200; e++) begin
            rand_event();
            run_stream(int'($urandom % 2), int'($urandom % 2));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule